// File: doc/BRIEF.md
# Supply Pulse Classifier

This block sits behind two comparators on a supply rail that is also used to carry commands. One flag says the rail is above a middle threshold, the other says it is above a top threshold; both arrive already synchronized to the block clock. Every sample is turned into one of three levels: low, mid or high. A pulse is a trip away from low and back. When the rail returns to low, the block reports the pulse as a mid pulse or a high pulse. The class is set by the highest level the rail reached during the trip. A high pulse that ramps up and down through the mid band is therefore never reported as a mid pulse.

A pulse counts only if the rail was low for enough samples before it and stayed at its peak level for enough samples. A trip that fails either test ends in an error strobe instead of an event. A qualified high pulse that held the high level long enough is also tagged as a blow pulse. All outputs are single-cycle strobes, registered, and appear in the cycle after the first low sample that ends the pulse. Every time limit is a parameter counted in clock ticks.

Top module: `supply_pulse_classifier`

## Requirements
- R1: The sample level is high whenever `above_high` is 1, whatever `above_mid` is. It is mid when only `above_mid` is 1, and low when both flags are 0.
- R2: A pulse whose peak is mid produces a one-cycle `mid_evt`. This needs at least MIN_LOW_TICKS low samples before the pulse and at least MIN_ACT_TICKS samples at mid. The strobe appears in the cycle after the first low sample that ends the pulse.
- R3: A pulse that reaches high is classified as high only, and then produces `high_evt`. Mid samples on its rising and falling ramps never produce `mid_evt`.
- R4: Dwell is counted only on samples at the peak level, and restarts when the peak rises from mid to high. A pulse with fewer than MIN_ACT_TICKS peak samples gives `err_evt` and no pulse event. This holds even when mid ramp samples make the whole trip long.
- R5: A pulse that starts after fewer than MIN_LOW_TICKS consecutive low samples gives `err_evt` when it ends. The next pulse with a full low gap is accepted normally.
- R6: `blow_evt` is raised together with `high_evt` exactly when the qualified high pulse held high for at least MIN_BLOW_TICKS samples. It is never raised without `high_evt`.
- R7: At most one of `mid_evt`, `high_evt` and `err_evt` is 1 in any cycle, and each lasts a single cycle.
- R8: During and after reset all strobes are 0. The low-gap count restarts at zero, so the first pulse needs a full low gap counted from the release of reset.
- R9: No strobe is raised while a pulse is still in progress. Strobes appear only in the cycle after a low sample that ends a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| above_mid | input | 1 | Synchronized flag: rail above the middle threshold |
| above_high | input | 1 | Synchronized flag: rail above the top threshold |
| mid_evt | output | 1 | One-cycle strobe: qualified mid pulse finished |
| high_evt | output | 1 | One-cycle strobe: qualified high pulse finished |
| blow_evt | output | 1 | One-cycle tag with `high_evt`: high held long enough to blow a fuse |
| err_evt | output | 1 | One-cycle strobe: pulse rejected, either too short at its peak or too little low before it |

## Verification
On every cycle the assertions check that the strobes are mutually exclusive and last one cycle, that a blow tag only comes with a high event, and that any strobe follows a low sample. They also tie each event class to the peak latched during the pulse, and check that a pulse started without enough low gap always ends in an error. The exact tick thresholds can be shown only by the bench's directed pulses. These are the boundaries of the low gap, the peak dwell and the blow length; the count restart when the peak climbs; a high pulse with long mid ramps; and the gap counted from reset.

// File: rtl/spc_pkg.sv
package spc_pkg;

  typedef enum logic [1:0] {
    LV_LOW  = 2'd0,
    LV_MID  = 2'd1,
    LV_HIGH = 2'd2
  } lvl_e;

  // R1: top flag dominates, mid flag alone gives mid, neither gives low
  function automatic lvl_e level_of(input logic mid_flag, input logic high_flag);
    if (high_flag)     return LV_HIGH;
    else if (mid_flag) return LV_MID;
    else               return LV_LOW;
  endfunction

  // a dwell count satisfies a limit when it has reached it
  function automatic logic meets(input int unsigned count, input int unsigned limit);
    return count >= limit;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/spc_level_dec.sv
module spc_level_dec
  import spc_pkg::*;
(
  input  logic above_mid,
  input  logic above_high,
  output lvl_e lvl
);

  always_comb lvl = level_of(above_mid, above_high);

endmodule

// File: rtl/spc_dwell_cnt.sv
module spc_dwell_cnt #(
  parameter int unsigned MAXV = 16,
  localparam int unsigned W = $clog2(MAXV + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load1,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] TOP = W'(MAXV);

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt <= '0;
    else if (clr)                 cnt <= '0;
    else if (load1)               cnt <= W'(1);
    else if (inc && cnt != TOP)   cnt <= cnt + W'(1);
  end

endmodule

// File: rtl/spc_excursion.sv
module spc_excursion
  import spc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  lvl_e lvl,
  input  logic low_ok,
  output logic in_exc,
  output lvl_e peak,
  output logic seq_ok,
  output logic exc_start,
  output logic peak_rise,
  output logic pulse_end
);

  always_comb begin
    exc_start = (lvl != LV_LOW) && !in_exc;
    peak_rise = in_exc && (lvl > peak);
    pulse_end = in_exc && (lvl == LV_LOW);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_exc <= 1'b0;
      peak   <= LV_LOW;
      seq_ok <= 1'b0;
    end else if (exc_start) begin
      in_exc <= 1'b1;
      peak   <= lvl;
      seq_ok <= low_ok;
    end else if (pulse_end) begin
      in_exc <= 1'b0;
      peak   <= LV_LOW;
    end else if (peak_rise) begin
      peak   <= lvl;
    end
  end

endmodule

// File: rtl/spc_classify.sv
module spc_classify
  import spc_pkg::*;
#(
  parameter int unsigned MIN_ACT_TICKS  = 8,
  parameter int unsigned MIN_BLOW_TICKS = 16,
  parameter int unsigned W              = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pulse_end,
  input  lvl_e         peak,
  input  logic         seq_ok,
  input  logic [W-1:0] act_cnt,
  output logic         mid_evt,
  output logic         high_evt,
  output logic         blow_evt,
  output logic         err_evt
);

  logic good, long_hi;

  always_comb begin
    good    = seq_ok && meets(32'(act_cnt), MIN_ACT_TICKS);
    long_hi = meets(32'(act_cnt), MIN_BLOW_TICKS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mid_evt  <= 1'b0;
      high_evt <= 1'b0;
      blow_evt <= 1'b0;
      err_evt  <= 1'b0;
    end else begin
      mid_evt  <= pulse_end && good && (peak == LV_MID);
      high_evt <= pulse_end && good && (peak == LV_HIGH);
      blow_evt <= pulse_end && good && (peak == LV_HIGH) && long_hi;
      err_evt  <= pulse_end && !good;
    end
  end

endmodule

// File: rtl/supply_pulse_classifier.sv
module supply_pulse_classifier
  import spc_pkg::*;
#(
  parameter int unsigned MIN_LOW_TICKS  = 8,
  parameter int unsigned MIN_ACT_TICKS  = 8,
  parameter int unsigned MIN_BLOW_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic above_mid,
  input  logic above_high,
  output logic mid_evt,
  output logic high_evt,
  output logic blow_evt,
  output logic err_evt
);

  localparam int unsigned CNT_MAX = max3(MIN_LOW_TICKS, MIN_ACT_TICKS, MIN_BLOW_TICKS);
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  lvl_e             lvl;
  lvl_e             peak_lvl;
  logic             in_exc, seq_ok, exc_start, peak_rise, pulse_end;
  logic             low_ok;
  logic [CNT_W-1:0] low_cnt, act_cnt;
  logic             at_low, at_peak;

  spc_level_dec u_dec (
    .above_mid (above_mid),
    .above_high(above_high),
    .lvl       (lvl)
  );

  always_comb begin
    at_low  = (lvl == LV_LOW);
    at_peak = in_exc && (lvl == peak_lvl) && !peak_rise;
    low_ok  = meets(32'(low_cnt), MIN_LOW_TICKS);
  end

  // consecutive low samples
  spc_dwell_cnt #(.MAXV(CNT_MAX)) u_low_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (!at_low),
    .load1(1'b0),
    .inc  (at_low),
    .cnt  (low_cnt)
  );

  // samples at the current peak level
  spc_dwell_cnt #(.MAXV(CNT_MAX)) u_act_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (at_low),
    .load1(exc_start || peak_rise),
    .inc  (at_peak),
    .cnt  (act_cnt)
  );

  spc_excursion u_exc (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (lvl),
    .low_ok   (low_ok),
    .in_exc   (in_exc),
    .peak     (peak_lvl),
    .seq_ok   (seq_ok),
    .exc_start(exc_start),
    .peak_rise(peak_rise),
    .pulse_end(pulse_end)
  );

  spc_classify #(
    .MIN_ACT_TICKS (MIN_ACT_TICKS),
    .MIN_BLOW_TICKS(MIN_BLOW_TICKS),
    .W             (CNT_W)
  ) u_cls (
    .clk      (clk),
    .rst_n    (rst_n),
    .pulse_end(pulse_end),
    .peak     (peak_lvl),
    .seq_ok   (seq_ok),
    .act_cnt  (act_cnt),
    .mid_evt  (mid_evt),
    .high_evt (high_evt),
    .blow_evt (blow_evt),
    .err_evt  (err_evt)
  );

endmodule

// File: rtl/spc_checker.sv
module spc_checker
  import spc_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic above_mid,
  input logic above_high,
  input logic mid_evt,
  input logic high_evt,
  input logic blow_evt,
  input logic err_evt,
  input lvl_e peak_lvl,
  input logic pulse_end,
  input logic seq_ok
);

  logic any_evt;
  always_comb any_evt = mid_evt || high_evt || err_evt;

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mid_evt, high_evt, err_evt}));

  a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |=> !any_evt);

  a_r6_blow_with_high: assert property (@(posedge clk) disable iff (!rst_n)
    blow_evt |-> high_evt);

  a_r9_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |-> $past(!above_mid && !above_high));

  a_r3_high_from_peak: assert property (@(posedge clk) disable iff (!rst_n)
    high_evt |-> $past(peak_lvl == LV_HIGH));

  a_r2_mid_from_peak: assert property (@(posedge clk) disable iff (!rst_n)
    mid_evt |-> $past(peak_lvl == LV_MID));

  a_r5_unarmed_errs: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_end && !seq_ok) |=> err_evt);

endmodule

bind supply_pulse_classifier spc_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .above_mid (above_mid),
  .above_high(above_high),
  .mid_evt   (mid_evt),
  .high_evt  (high_evt),
  .blow_evt  (blow_evt),
  .err_evt   (err_evt),
  .peak_lvl  (peak_lvl),
  .pulse_end (pulse_end),
  .seq_ok    (seq_ok)
);

// File: tb/tb_supply_pulse_classifier.sv
`timescale 1ns/1ps
module tb_supply_pulse_classifier;

  localparam int MIN_LOW  = 8;
  localparam int MIN_ACT  = 8;
  localparam int MIN_BLOW = 16;
  localparam int TAIL     = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic above_mid = 1'b0;
  logic above_high = 1'b0;
  logic mid_evt, high_evt, blow_evt, err_evt;

  int n_checks = 0;
  int n_errors = 0;
  int c_mid = 0, c_high = 0, c_blow = 0, c_err = 0;
  int low_before = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  supply_pulse_classifier #(
    .MIN_LOW_TICKS (MIN_LOW),
    .MIN_ACT_TICKS (MIN_ACT),
    .MIN_BLOW_TICKS(MIN_BLOW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .above_mid(above_mid), .above_high(above_high),
    .mid_evt(mid_evt), .high_evt(high_evt), .blow_evt(blow_evt), .err_evt(err_evt)
  );

  always @(negedge clk) begin
    c_mid  += int'(mid_evt);
    c_high += int'(high_evt);
    c_blow += int'(blow_evt);
    c_err  += int'(err_evt);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic m, input logic h, input int n);
    for (int i = 0; i < n; i++) begin
      above_mid  = m;
      above_high = h;
      @(negedge clk);
    end
  endtask

  // one pulse: gap low, pre mid ramp, top level, post mid ramp, then return
  task automatic pulse(input string req, input int gap, input int pre, input bit top_hi,
                       input bit hi_only, input int top_n, input int post);
    int s_mid, s_high, s_blow, s_err, dwell, e_mid, e_high, e_blow, e_err, any_now;
    bit armed;
    drive(1'b0, 1'b0, gap);
    low_before += gap;
    armed = (low_before >= MIN_LOW);
    s_mid = c_mid; s_high = c_high; s_blow = c_blow; s_err = c_err;
    drive(1'b1, 1'b0, pre);
    if (top_hi) drive(!hi_only, 1'b1, top_n);
    else        drive(1'b1, 1'b0, top_n);
    drive(1'b1, 1'b0, post);
    any_now = (c_mid - s_mid) + (c_high - s_high) + (c_err - s_err);
    chk(any_now == 0, "R9", {req, " strobe during pulse"}, any_now, 0);
    dwell  = top_hi ? top_n : pre + top_n + post;
    e_mid  = int'(armed && !top_hi && dwell >= MIN_ACT);
    e_high = int'(armed && top_hi && dwell >= MIN_ACT);
    e_blow = int'(e_high == 1 && dwell >= MIN_BLOW);
    e_err  = int'(!(armed && dwell >= MIN_ACT));
    above_mid = 1'b0; above_high = 1'b0;
    @(negedge clk);
    any_now = int'(mid_evt) + int'(high_evt) + int'(err_evt);
    chk(any_now == 1, "R9", {req, " strobe one cycle after return"}, any_now, 1);
    drive(1'b0, 1'b0, TAIL - 1);
    low_before = TAIL;
    chk(c_mid - s_mid == e_mid, req, "mid_evt count", c_mid - s_mid, e_mid);
    chk(c_high - s_high == e_high, req, "high_evt count", c_high - s_high, e_high);
    chk(c_blow - s_blow == e_blow, req, "blow_evt count", c_blow - s_blow, e_blow);
    chk(c_err - s_err == e_err, req, "err_evt count", c_err - s_err, e_err);
  endtask

  task automatic t_reset();
    int v;
    v = int'(mid_evt) + int'(high_evt) + int'(blow_evt) + int'(err_evt);
    chk(v == 0, "R8", "strobes in reset", v, 0);
    @(negedge clk);
    rst_n = 1'b1;
    low_before = 0;
    v = int'(mid_evt) + int'(high_evt) + int'(blow_evt) + int'(err_evt);
    chk(v == 0, "R8", "strobes after reset", v, 0);
  endtask

  task automatic t_peak_dip();
    int s_high, s_err;
    drive(1'b0, 1'b0, 10);
    s_high = c_high; s_err = c_err;
    drive(1'b1, 1'b1, 5);   // 5 high samples
    drive(1'b1, 1'b0, 4);   // dip to mid
    drive(1'b1, 1'b1, 5);   // 5 more high samples, 10 at peak in total
    drive(1'b0, 1'b0, TAIL);
    low_before = TAIL;
    chk(c_high - s_high == 1, "R4", "dip keeps high dwell", c_high - s_high, 1);
    chk(c_err - s_err == 0, "R4", "dip no error", c_err - s_err, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();                                  // R8
    pulse("R8", 5, 0, 1'b0, 1'b0, 10, 0);       // gap from reset too short: err
    pulse("R2", 6, 0, 1'b0, 1'b0, 10, 0);       // exactly MIN_LOW gap: mid
    pulse("R3", 10, 3, 1'b1, 1'b0, 10, 3);      // high through mid ramps
    pulse("R6", 10, 2, 1'b1, 1'b0, 20, 2);      // long high: blow
    pulse("R6", 10, 2, 1'b1, 1'b0, 16, 2);      // blow boundary
    pulse("R6", 10, 2, 1'b1, 1'b0, 15, 2);      // one short of blow
    pulse("R2", 10, 0, 1'b0, 1'b0, 8, 0);       // active boundary
    pulse("R4", 10, 0, 1'b0, 1'b0, 7, 0);       // one short: err
    pulse("R4", 10, 10, 1'b1, 1'b0, 4, 10);     // short high, long ramps: err
    pulse("R1", 10, 0, 1'b1, 1'b1, 10, 0);      // top flag alone is high
    pulse("R5", 5, 0, 1'b0, 1'b0, 10, 0);       // gap of 7: err
    pulse("R5", 6, 0, 1'b0, 1'b0, 10, 0);       // recovers with a full gap
    pulse("R7", 10, 0, 1'b1, 1'b0, 1, 0);       // single high sample: err
    t_peak_dip();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule